// File: doc/BRIEF.md
# Single-Precision Compare, Min/Max and Classify Unit

This unit takes two IEEE single-precision operands and an operation code and produces one of three kinds of answer: a boolean from an equality, less-than or less-or-equal test, the smaller or larger of the two operands, or a ten-bit class mask describing the first operand. Alongside the result it produces a five-bit exception flag vector. In this vector only the invalid-operation bit can ever be set.

The unit is fully combinational up to a single output register stage. A request presented with `in_valid` high is answered on the following clock edge with `out_valid` high. When no request is presented, the outputs keep their last value and `out_valid` stays low. It is meant to sit beside an arithmetic pipeline and serve the non-arithmetic operations, which need no rounding.

The NaN rules work as follows. A NaN is signaling when its exponent is all ones, its mantissa is nonzero and mantissa bit 22 is clear. Compares treat any NaN as unordered. Min/max prefers a number over a NaN. Only min/max orders negative zero below positive zero.

Top module: `fcmp_unit`

## Requirements
- R1: A request accepted with `in_valid` high at a rising edge shows its `result` and `flags` after that same edge, with `out_valid` high. A cycle with `in_valid` low leaves `out_valid` low after the edge, and `result` and `flags` unchanged whatever `op`, `opa` and `opb` carry.
- R2: While `rst_n` is low at a rising edge, `out_valid`, `result` and `flags` all become zero.
- R3: The compare ops are selected by op 0 (equal), 1 (less-than) and 2 (less-or-equal). They return 1 or 0 in result bit 0 with bits 31..1 zero. They use ordinary numeric order, and +0 and -0 compare equal.
- R4: When either compare operand is a NaN, the compare result is 0. Less-than and less-or-equal raise invalid for any NaN operand. Equality raises invalid only when an operand is a signaling NaN (exponent all ones, mantissa nonzero, mantissa bit 22 clear).
- R5: Op 3 (minimum) returns the numerically smaller operand and op 4 (maximum) returns the larger one, bit for bit. For these two ops, -0 (0x80000000) counts as smaller than +0 (0x00000000).
- R6: If exactly one min/max operand is a NaN, the other operand is returned unchanged. If both are NaNs, the result is 0x7FC00000.
- R7: Min/max raises invalid whenever either operand is a signaling NaN, even when the result is a number. Quiet NaNs raise nothing.
- R8: Op 5 (classify) writes a one-hot mask for `opa` into result bits 9..0: bit 0 -inf, 1 negative normal, 2 negative subnormal, 3 -0, 4 +0, 5 positive subnormal, 6 positive normal, 7 +inf, 8 signaling NaN, 9 quiet NaN. Bits 31..10 are zero and no flag is raised.
- R9: The invalid flag is `flags` bit 4. Flag bits 3..0 are always zero.
- R10: Op codes 6 and 7 are reserved. They give a zero result and zero flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| op | input | 3 | Operation code (see R3, R5, R8, R10) |
| opa | input | 32 | First operand (classified operand for op 5) |
| opb | input | 32 | Second operand |
| out_valid | output | 1 | Result registered from a request on the previous edge |
| result | output | 32 | Boolean, selected operand, or class mask |
| flags | output | 5 | Exception flags, bit 4 invalid |

## Verification
Compares are exercised with operands of equal and differing signs, with equal values, and with the two zeros. This separates a sign-magnitude order from a plain unsigned order, and shows whether both zeros are folded together. Quiet and signaling NaNs are placed in each operand position under each compare and under min/max. This tells apart the signaling and quiet flag rules and the number-over-NaN preference, and checks that the canonical pattern appears rather than a propagated payload. Every class value is presented once, so a swapped pair of mask bits shows up. Idle cycles with changing inputs separate a held output from one that follows the inputs.

// File: rtl/fcmp_pkg.sv
// Package: shared widths, operation codes and operand kind record for the
// single-precision compare unit. Assumes the IEEE binary32 layout.
package fcmp_pkg;
    localparam int EXP_W  = 8;
    localparam int MAN_W  = 23;
    localparam int FP_W   = 1 + EXP_W + MAN_W;
    localparam int CLS_W  = 10;
    localparam int FLG_W  = 5;
    localparam int NV_BIT = 4;
    localparam int OP_W   = 3;

    localparam logic [FP_W-1:0] CANON_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

    localparam logic [OP_W-1:0] OP_EQ    = 3'd0;
    localparam logic [OP_W-1:0] OP_LT    = 3'd1;
    localparam logic [OP_W-1:0] OP_LE    = 3'd2;
    localparam logic [OP_W-1:0] OP_MIN   = 3'd3;
    localparam logic [OP_W-1:0] OP_MAX   = 3'd4;
    localparam logic [OP_W-1:0] OP_CLASS = 3'd5;

    typedef struct packed {
        logic sign;
        logic zero;
        logic sub;
        logic norm;
        logic inf;
        logic nan;
        logic snan;
    } fkind_t;
endpackage

// File: rtl/fcmp_inspect.sv
// Module: fcmp_inspect
// Decodes one binary32 operand into a kind record (zero, subnormal, normal,
// infinity, NaN, signaling NaN, sign). Purely combinational.
// Assumes: a NaN is signaling when its top mantissa bit is clear.
module fcmp_inspect
    import fcmp_pkg::*;
(
    input  logic [FP_W-1:0] val,
    output fkind_t          kind
);
    logic exp_ones, exp_zero, man_nz, quiet_bit;

    // Field summaries
    always_comb begin
        exp_ones  = &val[FP_W-2:MAN_W];
        exp_zero  = ~|val[FP_W-2:MAN_W];
        man_nz    = |val[MAN_W-1:0];
        quiet_bit = val[MAN_W-1];
    end

    // Kind record assembly
    always_comb begin
        kind.sign = val[FP_W-1];
        kind.zero = exp_zero & ~man_nz;
        kind.sub  = exp_zero & man_nz;
        kind.norm = ~exp_zero & ~exp_ones;
        kind.inf  = exp_ones & ~man_nz;
        kind.nan  = exp_ones & man_nz;
        kind.snan = exp_ones & man_nz & ~quiet_bit;
    end
endmodule

// File: rtl/fcmp_order.sv
// Module: fcmp_order
// Orders two binary32 operands. Gives IEEE compares (zeros equal, NaN
// unordered) and min/max selection (-0 below +0, number preferred over NaN,
// canonical NaN when both are NaN). Combinational.
module fcmp_order
    import fcmp_pkg::*;
(
    input  logic [FP_W-1:0] a,
    input  logic [FP_W-1:0] b,
    input  fkind_t          ka,
    input  fkind_t          kb,
    output logic            is_eq,
    output logic            is_lt,
    output logic            is_le,
    output logic [FP_W-1:0] min_val,
    output logic [FP_W-1:0] max_val,
    output logic            any_nan,
    output logic            any_snan
);
    logic mag_lt, mag_gt, both_zero, total_lt;

    // Sign-magnitude order with -0 strictly below +0
    always_comb begin
        mag_lt    = a[FP_W-2:0] < b[FP_W-2:0];
        mag_gt    = b[FP_W-2:0] < a[FP_W-2:0];
        both_zero = ka.zero & kb.zero;
        any_nan   = ka.nan | kb.nan;
        any_snan  = ka.snan | kb.snan;
        if (ka.sign != kb.sign) total_lt = ka.sign;
        else if (ka.sign)       total_lt = mag_gt;
        else                    total_lt = mag_lt;
    end

    // IEEE compare outcomes
    always_comb begin
        is_eq = ~any_nan & ((a == b) | both_zero);
        is_lt = ~any_nan & ~both_zero & total_lt;
        is_le = is_lt | is_eq;
    end

    // Minimum and maximum selection
    always_comb begin
        if (ka.nan & kb.nan) begin
            min_val = CANON_NAN;
            max_val = CANON_NAN;
        end else if (ka.nan) begin
            min_val = b;
            max_val = b;
        end else if (kb.nan) begin
            min_val = a;
            max_val = a;
        end else begin
            min_val = total_lt ? a : b;
            max_val = total_lt ? b : a;
        end
    end
endmodule

// File: rtl/fcmp_classify.sv
// Module: fcmp_classify
// Turns an operand kind record into the ten-bit one-hot class mask.
// Assumes the kind record is self-consistent (exactly one category true).
module fcmp_classify
    import fcmp_pkg::*;
(
    input  fkind_t           kind,
    output logic [CLS_W-1:0] mask
);
    // Mask bit placement by class
    always_comb begin
        mask    = '0;
        mask[0] = kind.inf  &  kind.sign;
        mask[1] = kind.norm &  kind.sign;
        mask[2] = kind.sub  &  kind.sign;
        mask[3] = kind.zero &  kind.sign;
        mask[4] = kind.zero & ~kind.sign;
        mask[5] = kind.sub  & ~kind.sign;
        mask[6] = kind.norm & ~kind.sign;
        mask[7] = kind.inf  & ~kind.sign;
        mask[8] = kind.snan;
        mask[9] = kind.nan  & ~kind.snan;
    end
endmodule

// File: rtl/fcmp_unit.sv
// Module: fcmp_unit (top)
// Compare / min / max / classify unit for binary32 operands with one
// registered output stage. Assumes requests arrive at most one per cycle;
// outputs hold when no request is present. Synchronous active-low reset.
module fcmp_unit
    import fcmp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [OP_W-1:0]  op,
    input  logic [FP_W-1:0]  opa,
    input  logic [FP_W-1:0]  opb,
    output logic             out_valid,
    output logic [FP_W-1:0]  result,
    output logic [FLG_W-1:0] flags
);
    fkind_t           kind_a, kind_b;
    logic             eq_w, lt_w, le_w, nan_w, snan_w;
    logic [FP_W-1:0]  min_w, max_w;
    logic [CLS_W-1:0] cls_w;
    logic [FP_W-1:0]  res_nx;
    logic             nv_nx;

    fcmp_inspect u_insp_a (.val(opa), .kind(kind_a));
    fcmp_inspect u_insp_b (.val(opb), .kind(kind_b));

    fcmp_order u_order (
        .a(opa), .b(opb), .ka(kind_a), .kb(kind_b),
        .is_eq(eq_w), .is_lt(lt_w), .is_le(le_w),
        .min_val(min_w), .max_val(max_w),
        .any_nan(nan_w), .any_snan(snan_w)
    );

    fcmp_classify u_class (.kind(kind_a), .mask(cls_w));

    // Result and invalid-flag selection by operation code
    always_comb begin
        res_nx = '0;
        nv_nx  = 1'b0;
        case (op)
            OP_EQ:    begin res_nx[0] = eq_w; nv_nx = snan_w; end
            OP_LT:    begin res_nx[0] = lt_w; nv_nx = nan_w;  end
            OP_LE:    begin res_nx[0] = le_w; nv_nx = nan_w;  end
            OP_MIN:   begin res_nx = min_w;   nv_nx = snan_w; end
            OP_MAX:   begin res_nx = max_w;   nv_nx = snan_w; end
            OP_CLASS: res_nx[CLS_W-1:0] = cls_w;
            default:  res_nx = '0;
        endcase
    end

    // Output register stage with hold on idle cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            flags     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= res_nx;
                flags  <= '0;
                flags[NV_BIT] <= nv_nx;
            end
        end
    end
endmodule

// File: rtl/fcmp_unit_chk.sv
// Module: fcmp_unit_chk
// Property checker for fcmp_unit, attached by bind. Observes ports only.
module fcmp_unit_chk
    import fcmp_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [OP_W-1:0]  op,
    input logic [FP_W-1:0]  opa,
    input logic [FP_W-1:0]  opb,
    input logic             out_valid,
    input logic [FP_W-1:0]  result,
    input logic [FLG_W-1:0] flags
);
    logic a_is_nan, b_is_nan;

    // Independent NaN detection on the inputs
    always_comb begin
        a_is_nan = (&opa[FP_W-2:MAN_W]) & (|opa[MAN_W-1:0]);
        b_is_nan = (&opb[FP_W-2:MAN_W]) & (|opb[MAN_W-1:0]);
    end

    a_r1_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result) && $stable(flags)));

    a_r2_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && result == '0 && flags == '0));

    a_r3_bool_width: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op <= OP_LE) |=> (result[FP_W-1:1] == '0));

    a_r4_nan_unordered: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op <= OP_LE && (a_is_nan || b_is_nan)) |=> (result == '0));

    a_r6_both_nan: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == OP_MIN || op == OP_MAX) && a_is_nan && b_is_nan)
        |=> (result == CANON_NAN));

    a_r8_class_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_CLASS) |=>
        ($countones(result[CLS_W-1:0]) == 1 && result[FP_W-1:CLS_W] == '0 && flags == '0));

    a_r9_low_flags: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (flags[NV_BIT-1:0] == '0));

    a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op > OP_CLASS) |=> (result == '0 && flags == '0));
endmodule

bind fcmp_unit fcmp_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .opa(opa), .opb(opb), .out_valid(out_valid),
    .result(result), .flags(flags)
);

// File: tb/sim_fcmp_unit.sv
// Bench for fcmp_unit: a vector table walked by one loop, then directed
// tests for reset, idle hold and mid-run reset.
module sim_fcmp_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [2:0]  op;
    logic [31:0] opa, opb;
    logic        out_valid;
    logic [31:0] result;
    logic [4:0]  flags;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    fcmp_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .opa(opa), .opb(opb), .out_valid(out_valid),
        .result(result), .flags(flags)
    );

    // {op, opa, opb, expected result, expected flags}
    localparam int NV = 41;
    localparam logic [103:0] VEC [NV] = '{
        {3'd0, 32'h3F800000, 32'h3F800000, 32'h00000001, 5'h00}, // R3 1==1
        {3'd0, 32'h00000000, 32'h80000000, 32'h00000001, 5'h00}, // R3 +0==-0
        {3'd0, 32'h3F800000, 32'h40000000, 32'h00000000, 5'h00}, // R3
        {3'd1, 32'h3F800000, 32'h40000000, 32'h00000001, 5'h00}, // R3 1<2
        {3'd1, 32'h40000000, 32'h3F800000, 32'h00000000, 5'h00}, // R3
        {3'd1, 32'hC0000000, 32'hBF800000, 32'h00000001, 5'h00}, // R3 -2<-1
        {3'd1, 32'hBF800000, 32'h3F800000, 32'h00000001, 5'h00}, // R3 -1<1
        {3'd1, 32'h80000000, 32'h00000000, 32'h00000000, 5'h00}, // R3 -0<+0 false
        {3'd1, 32'hFF800000, 32'h00000001, 32'h00000001, 5'h00}, // R3 -inf<sub
        {3'd2, 32'h3F800000, 32'h3F800000, 32'h00000001, 5'h00}, // R3
        {3'd2, 32'h80000000, 32'h00000000, 32'h00000001, 5'h00}, // R3
        {3'd2, 32'h40000000, 32'hBF800000, 32'h00000000, 5'h00}, // R3
        {3'd0, 32'h7FC00000, 32'h3F800000, 32'h00000000, 5'h00}, // R4 qNaN eq quiet
        {3'd0, 32'h7F800001, 32'h3F800000, 32'h00000000, 5'h10}, // R4 sNaN eq
        {3'd0, 32'h7FC00000, 32'h7FC00000, 32'h00000000, 5'h00}, // R4
        {3'd1, 32'h7FC00000, 32'h3F800000, 32'h00000000, 5'h10}, // R4 lt qNaN
        {3'd2, 32'h3F800000, 32'h7FC00000, 32'h00000000, 5'h10}, // R4 le qNaN
        {3'd3, 32'h3F800000, 32'h40000000, 32'h3F800000, 5'h00}, // R5
        {3'd4, 32'h3F800000, 32'h40000000, 32'h40000000, 5'h00}, // R5
        {3'd3, 32'hC0000000, 32'hBF800000, 32'hC0000000, 5'h00}, // R5
        {3'd4, 32'hC0000000, 32'hBF800000, 32'hBF800000, 5'h00}, // R5
        {3'd3, 32'h00000000, 32'h80000000, 32'h80000000, 5'h00}, // R5 min zeros
        {3'd4, 32'h80000000, 32'h00000000, 32'h00000000, 5'h00}, // R5 max zeros
        {3'd3, 32'h7FC00123, 32'h3FC00000, 32'h3FC00000, 5'h00}, // R6
        {3'd4, 32'h3FC00000, 32'h7FC00000, 32'h3FC00000, 5'h00}, // R6
        {3'd3, 32'h7FC00000, 32'h7FC00123, 32'h7FC00000, 5'h00}, // R6 canonical
        {3'd4, 32'h7F800001, 32'h3F800000, 32'h3F800000, 5'h10}, // R7
        {3'd3, 32'h7F800001, 32'h7FC00000, 32'h7FC00000, 5'h10}, // R7 R6
        {3'd3, 32'hFF800000, 32'h80000001, 32'hFF800000, 5'h00}, // R5
        {3'd5, 32'hFF800000, 32'h0, 32'h00000001, 5'h00},        // R8
        {3'd5, 32'hBF800000, 32'h0, 32'h00000002, 5'h00},        // R8
        {3'd5, 32'h80000001, 32'h0, 32'h00000004, 5'h00},        // R8
        {3'd5, 32'h80000000, 32'h0, 32'h00000008, 5'h00},        // R8
        {3'd5, 32'h00000000, 32'h0, 32'h00000010, 5'h00},        // R8
        {3'd5, 32'h00000001, 32'h0, 32'h00000020, 5'h00},        // R8
        {3'd5, 32'h3F800000, 32'h0, 32'h00000040, 5'h00},        // R8
        {3'd5, 32'h7F800000, 32'h0, 32'h00000080, 5'h00},        // R8
        {3'd5, 32'h7F800001, 32'h0, 32'h00000100, 5'h00},        // R8
        {3'd5, 32'h7FC00000, 32'h0, 32'h00000200, 5'h00},        // R8
        {3'd6, 32'h3F800000, 32'h40000000, 32'h00000000, 5'h00}, // R10
        {3'd7, 32'h7F800001, 32'h7F800001, 32'h00000000, 5'h00}  // R10
    };

    task automatic check(input string tag, input logic [37:0] got, input logic [37:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got valid/result/flags %h, expected %h", tag, got, exp);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; op = '0; opa = '0; opb = '0;
        repeat (3) @(negedge clk);
        // R2: reset state
        check("R2 reset state", {out_valid, result, flags}, 38'h0);
        rst_n = 1'b1;

        // Vector walk; R1 timing and R9 flag bits checked on every vector
        for (int i = 0; i < NV; i++) begin
            op = VEC[i][103:101]; opa = VEC[i][100:69]; opb = VEC[i][68:37];
            in_valid = 1'b1;
            @(negedge clk);
            check($sformatf("vector %0d (R1 R9 and tagged req)", i),
                  {out_valid, result, flags}, {1'b1, VEC[i][36:0]});
        end

        // R1: idle cycles hold the last result while inputs change
        op = 3'd4; opa = 32'h3F800000; opb = 32'h40000000; in_valid = 1'b1;
        @(negedge clk);
        check("R1 load max", {out_valid, result, flags}, {1'b1, 32'h40000000, 5'h00});
        in_valid = 1'b0; op = 3'd1; opa = 32'h7FC00000; opb = 32'h0;
        @(negedge clk);
        check("R1 idle hold a", {out_valid, result, flags}, {1'b0, 32'h40000000, 5'h00});
        op = 3'd5; opa = 32'h7F800001;
        @(negedge clk);
        check("R1 idle hold b", {out_valid, result, flags}, {1'b0, 32'h40000000, 5'h00});

        // R2: mid-run reset with a request pending
        op = 3'd1; opa = 32'h7FC00000; opb = 32'h0; in_valid = 1'b1;
        @(negedge clk);
        check("R4 flagged result before reset", {out_valid, result, flags}, {1'b1, 32'h0, 5'h10});
        rst_n = 1'b0;
        @(negedge clk);
        check("R2 mid-run reset", {out_valid, result, flags}, 38'h0);
        rst_n = 1'b1; in_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        summary();
        $finish;
    end

    // Watchdog
    initial begin
        #1000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, got timeout, expected finish");
            summary();
            $finish;
        end
    end
endmodule